// File: doc/BRIEF.md
# Receive Frame Descriptor Status Engine

This block looks after the receive frame descriptors that software keeps in a shared, word-addressed memory. On a start command it reads the descriptor at a given address. On the start of a frame it marks that descriptor busy. It then waits for the end of the frame, when the receive datapath reports the per-frame error flags. At that point it writes back one 16-bit status word carrying the completion flag, the error summary and the individual error bits.

Whether a bad frame is written back or thrown away depends on a save-bad-frames setting. A thrown-away frame leaves the descriptor free for the next frame. After a written-back frame the engine follows the descriptor's link word to the next descriptor. It stops instead when the descriptor's control word carries an end-of-list flag or a suspend flag. Every frame with errors pulses per-error statistics strobes, whether it is kept or not, so that an external counter block can count it.

Each descriptor occupies four consecutive 16-bit words at base address A:

| Address | Contents |
|---|---|
| A+0 | status word, written by the engine |
| A+1 | control word |
| A+2 | absolute word address of the next descriptor |
| A+3 | buffer-descriptor pointer |

Top module: `rfd_status_engine`

## Requirements
- R1: After reset `mem_req`, `susp_req`, `rx_ready` and `stat_pulse` are 0 and `eng_idle` is 1.
- R2: A `start_cmd` in the idle state loads `start_addr` and reads the words at A+1, A+2 and A+3, in that order. Once those reads are done, `rx_ready` is raised.
- R3: Only one memory request is outstanding at a time. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until the single-cycle `mem_ack` arrives, so no descriptor read begins before the previous status write has been acknowledged.
- R4: An `rx_sof` while `rx_ready` is high writes 0x4000 (busy bit 14 set) to A+0. An `rx_sof` or `rx_eof` arriving outside a frame has no effect.
- R5: On `rx_eof` the status word written to A+0 has the following bits:
  - bit 15 is 1 and bit 14 is 0;
  - bit 13 is 1 only for a frame with no effective error and no truncation;
  - error inputs `rx_err[7:1]` map as follows: crc(1) to bit 11, align(2) to bit 10, no-resources(3) to bit 9, overrun(4) to bit 8, short(5) to bit 7, no-end-flag(6) to bit 6, collision(7) to bit 0.
- R6: The length error `rx_err[0]` appears at status bit 12, and counts as an error, only while `cfg_len_chk` is 1.
- R7: Status bit 5 repeats `rx_trunc` only when control bit 3 is 0 and `cfg_save_bad` is 1; otherwise it is 0. Bits 4 to 2 are always 0, and bit 1 repeats `rx_da_miss`.
- R8: A frame with an error or truncation while `cfg_save_bad` is 0 is discarded: 0x0000 is written to A+0 and the same descriptor becomes ready again with no read.
- R9: After a written-back frame whose control bits 15 and 14 are both 0, the engine fetches the descriptor at the link address. A link that points back to an earlier descriptor forms a cyclic list.
- R10: After a written-back frame with control bit 15 (end of list) set, the engine goes idle and reads nothing more. `start_cmd` is acted on only in the idle state.
- R11: After a written-back frame with control bit 14 set and bit 15 clear, `susp_req` stays high until `resume`, which fetches the link address. Bit 15 takes precedence over bit 14.
- R12: After fetching a descriptor, `rbd_ptr` holds its buffer pointer. `rbd_attached` is 0 when that pointer is all ones and 1 otherwise.
- R13: One cycle after an `rx_eof` is taken, `stat_pulse` holds the effective error vector (bit 0 masked by `cfg_len_chk`) for exactly one cycle, for kept and discarded frames alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_save_bad | input | 1 | Write back frames with errors instead of discarding them |
| cfg_len_chk | input | 1 | Treat the length error input as an error |
| start_cmd | input | 1 | Begin walking the list at `start_addr` (idle only) |
| start_addr | input | ADDR_W | Word address of the first descriptor |
| resume | input | 1 | Leave the suspended state |
| rx_sof | input | 1 | Frame reception setup begins |
| rx_eof | input | 1 | Frame ended; error inputs valid |
| rx_err | input | 8 | Error flags: 0 length, 1 crc, 2 align, 3 no resources, 4 overrun, 5 short, 6 no end flag, 7 collision |
| rx_trunc | input | 1 | Frame was truncated |
| rx_da_miss | input | 1 | Destination address differed from the individual address |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Single-cycle acknowledge |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| rx_ready | output | 1 | A descriptor is armed for the next frame |
| susp_req | output | 1 | Suspend request |
| eng_idle | output | 1 | Engine is idle |
| rbd_ptr | output | ADDR_W | Buffer pointer of the current descriptor |
| rbd_attached | output | 1 | Buffer pointer is not all ones |
| stat_pulse | output | 8 | Per-error statistics strobes, same bit order as `rx_err` |

## Verification
A new start command can coincide with the acknowledge of the final status write of an end-of-list descriptor. The bench holds `start_cmd` high from the end of that frame until after the cycle in which the write is acknowledged, and drops it before the engine can reach the idle state. The engine must end idle and not suspended, and the access scoreboard must see no further memory access. A read after that point would pop an empty queue and be reported.

// File: rtl/rfd_pkg.sv
`timescale 1ns/1ps
package rfd_pkg;
  localparam int STAT_W = 16;
  localparam int NERR   = 8;

  // descriptor word offsets
  localparam int OFS_STATUS = 0;
  localparam int OFS_CTRL   = 1;
  localparam int OFS_LINK   = 2;
  localparam int OFS_RBD    = 3;

  // control word bits
  localparam int CTL_EOL  = 15;
  localparam int CTL_SUSP = 14;
  localparam int CTL_FLEX = 3;

  // status word bits
  localparam int ST_DONE   = 15;
  localparam int ST_BUSY   = 14;
  localparam int ST_OK     = 13;
  localparam int ST_TRUNC  = 5;
  localparam int ST_DAMISS = 1;

  // error input indices
  localparam int E_LEN   = 0;
  localparam int E_CRC   = 1;
  localparam int E_ALIGN = 2;
  localparam int E_NORES = 3;
  localparam int E_OVR   = 4;
  localparam int E_SHORT = 5;
  localparam int E_NOEOP = 6;
  localparam int E_COLL  = 7;

  typedef enum logic [3:0] {
    W_IDLE, W_RD_CTL, W_RD_LINK, W_RD_RBD, W_READY,
    W_WR_BUSY, W_RECV, W_WR_STAT, W_SUSP
  } walk_state_t;

  // status bit position of each error input
  function automatic int err_bit(input int idx);
    case (idx)
      E_LEN:   return 12;
      E_CRC:   return 11;
      E_ALIGN: return 10;
      E_NORES: return 9;
      E_OVR:   return 8;
      E_SHORT: return 7;
      E_NOEOP: return 6;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/rfd_mem_port.sv
`timescale 1ns/1ps
module rfd_mem_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  assign cmd_ready = !mem_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_done  <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_done <= 1'b0;
      if (mem_req) begin
        if (mem_ack) begin
          mem_req  <= 1'b0;
          rsp_done <= 1'b1;
          rsp_data <= mem_rdata;
        end
      end else if (cmd_valid) begin
        mem_req   <= 1'b1;
        mem_we    <= cmd_we;
        mem_addr  <= cmd_addr;
        mem_wdata <= cmd_wdata;
      end
    end
  end

  // request fields frozen while waiting for the acknowledge
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_done_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> ($past(mem_req) && $past(mem_ack) && !mem_req));
endmodule

// File: rtl/rfd_status_build.sv
`timescale 1ns/1ps
module rfd_status_build
  import rfd_pkg::*;
#(
  parameter int N_ERR = NERR
) (
  input  logic [N_ERR-1:0]  errs,
  input  logic              trunc,
  input  logic              da_miss,
  input  logic              flex,
  input  logic              cfg_len_chk,
  input  logic              cfg_save_bad,
  output logic [STAT_W-1:0] status,
  output logic              keep
);
  logic [N_ERR-1:0] errs_eff;
  logic             bad;

  always_comb begin
    errs_eff        = errs;
    errs_eff[E_LEN] = errs[E_LEN] & cfg_len_chk;
    bad             = (|errs_eff) | trunc;
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < N_ERR; i++) begin
      status[err_bit(i)] = errs_eff[i];
    end
    status[ST_TRUNC]  = trunc & ~flex & cfg_save_bad;
    status[ST_DAMISS] = da_miss;
    status[ST_OK]     = ~bad;
    status[ST_DONE]   = 1'b1;
    keep              = ~bad | cfg_save_bad;
  end
endmodule

// File: rtl/rfd_stat_strobe.sv
`timescale 1ns/1ps
module rfd_stat_strobe #(
  parameter int N_ERR = 8,
  parameter int LEN_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [N_ERR-1:0] errs,
  input  logic             cfg_len_chk,
  output logic [N_ERR-1:0] pulse
);
  logic [N_ERR-1:0] masked;

  always_comb begin
    masked          = errs;
    masked[LEN_IDX] = errs[LEN_IDX] & cfg_len_chk;
  end

  always_ff @(posedge clk) begin
    if (rst) pulse <= '0;
    else     pulse <= accept ? masked : '0;
  end

  assert_pulse_single_R13: assert property (@(posedge clk) disable iff (rst)
    (|pulse) |=> (pulse == '0));
endmodule

// File: rtl/rfd_walker.sv
`timescale 1ns/1ps
module rfd_walker
  import rfd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_ERR  = NERR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              resume,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [N_ERR-1:0]  rx_err,
  input  logic              rx_trunc,
  input  logic              rx_da_miss,
  output logic              cmd_valid,
  output logic              cmd_we,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [STAT_W-1:0] cmd_wdata,
  input  logic              cmd_ready,
  input  logic              rsp_done,
  input  logic [STAT_W-1:0] rsp_data,
  input  logic [STAT_W-1:0] stat_word,
  input  logic              stat_keep,
  output logic [N_ERR-1:0]  cap_errs,
  output logic              cap_trunc,
  output logic              cap_damiss,
  output logic              ctl_flex,
  output logic              eof_accept,
  output logic              rx_ready,
  output logic              susp_req,
  output logic              eng_idle,
  output logic [ADDR_W-1:0] rbd_ptr,
  output logic              rbd_attached
);
  localparam logic [STAT_W-1:0] BUSY_WORD = STAT_W'(1) << ST_BUSY;

  walk_state_t       state;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] link_r;
  logic              ctl_eol;
  logic              ctl_susp;
  logic              pending;
  logic              eof_seen;

  assign eof_accept = rx_eof && !eof_seen && (state == W_WR_BUSY || state == W_RECV);
  assign rx_ready   = (state == W_READY);
  assign susp_req   = (state == W_SUSP);
  assign eng_idle   = (state == W_IDLE);

  always_comb begin
    cmd_valid = 1'b0;
    cmd_we    = 1'b0;
    cmd_addr  = cur_addr;
    cmd_wdata = '0;
    case (state)
      W_RD_CTL: begin
        cmd_valid = !pending;
        cmd_addr  = cur_addr + ADDR_W'(OFS_CTRL);
      end
      W_RD_LINK: begin
        cmd_valid = !pending;
        cmd_addr  = cur_addr + ADDR_W'(OFS_LINK);
      end
      W_RD_RBD: begin
        cmd_valid = !pending;
        cmd_addr  = cur_addr + ADDR_W'(OFS_RBD);
      end
      W_WR_BUSY: begin
        cmd_valid = !pending;
        cmd_we    = 1'b1;
        cmd_addr  = cur_addr + ADDR_W'(OFS_STATUS);
        cmd_wdata = BUSY_WORD;
      end
      W_WR_STAT: begin
        cmd_valid = !pending;
        cmd_we    = 1'b1;
        cmd_addr  = cur_addr + ADDR_W'(OFS_STATUS);
        cmd_wdata = stat_keep ? stat_word : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= W_IDLE;
      cur_addr     <= '0;
      link_r       <= '0;
      ctl_eol      <= 1'b0;
      ctl_susp     <= 1'b0;
      ctl_flex     <= 1'b0;
      pending      <= 1'b0;
      eof_seen     <= 1'b0;
      cap_errs     <= '0;
      cap_trunc    <= 1'b0;
      cap_damiss   <= 1'b0;
      rbd_ptr      <= '0;
      rbd_attached <= 1'b0;
    end else begin
      if (cmd_valid && cmd_ready) pending <= 1'b1;
      if (rsp_done)               pending <= 1'b0;
      if (eof_accept) begin
        eof_seen   <= 1'b1;
        cap_errs   <= rx_err;
        cap_trunc  <= rx_trunc;
        cap_damiss <= rx_da_miss;
      end
      case (state)
        W_IDLE: if (start_cmd) begin
          cur_addr <= start_addr;
          state    <= W_RD_CTL;
        end
        W_RD_CTL: if (rsp_done) begin
          ctl_eol  <= rsp_data[CTL_EOL];
          ctl_susp <= rsp_data[CTL_SUSP];
          ctl_flex <= rsp_data[CTL_FLEX];
          state    <= W_RD_LINK;
        end
        W_RD_LINK: if (rsp_done) begin
          link_r <= rsp_data[ADDR_W-1:0];
          state  <= W_RD_RBD;
        end
        W_RD_RBD: if (rsp_done) begin
          rbd_ptr      <= rsp_data[ADDR_W-1:0];
          rbd_attached <= ~(&rsp_data[ADDR_W-1:0]);
          state        <= W_READY;
        end
        W_READY: if (rx_sof) begin
          eof_seen <= 1'b0;
          state    <= W_WR_BUSY;
        end
        W_WR_BUSY: if (rsp_done) state <= W_RECV;
        W_RECV: if (eof_seen) state <= W_WR_STAT;
        W_WR_STAT: if (rsp_done) begin
          eof_seen <= 1'b0;
          if (!stat_keep)    state <= W_READY;
          else if (ctl_eol)  state <= W_IDLE;
          else if (ctl_susp) state <= W_SUSP;
          else begin
            cur_addr <= link_r;
            state    <= W_RD_CTL;
          end
        end
        W_SUSP: if (resume) begin
          cur_addr <= link_r;
          state    <= W_RD_CTL;
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  assert_fetch_after_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (state == W_RD_CTL && $past(state) == W_WR_STAT) |-> $past(rsp_done));

  assert_eol_stops_R10: assert property (@(posedge clk) disable iff (rst)
    (state == W_WR_STAT && rsp_done && stat_keep && ctl_eol) |=> (state == W_IDLE));

  assert_discard_reuse_R8: assert property (@(posedge clk) disable iff (rst)
    (state == W_WR_STAT && rsp_done && !stat_keep) |=> (state == W_READY && $stable(cur_addr)));

  assert_susp_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (state == W_SUSP && !resume) |=> (state == W_SUSP));
endmodule

// File: rtl/rfd_status_engine.sv
`timescale 1ns/1ps
module rfd_status_engine
  import rfd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_save_bad,
  input  logic              cfg_len_chk,
  input  logic              start_cmd,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              resume,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [NERR-1:0]   rx_err,
  input  logic              rx_trunc,
  input  logic              rx_da_miss,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [STAT_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [STAT_W-1:0] mem_rdata,
  output logic              rx_ready,
  output logic              susp_req,
  output logic              eng_idle,
  output logic [ADDR_W-1:0] rbd_ptr,
  output logic              rbd_attached,
  output logic [NERR-1:0]   stat_pulse
);
  logic              cmd_valid, cmd_we, cmd_ready, rsp_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [STAT_W-1:0] cmd_wdata, rsp_data, stat_word;
  logic              stat_keep, cap_trunc, cap_damiss, ctl_flex, eof_accept;
  logic [NERR-1:0]   cap_errs;

  rfd_walker #(.ADDR_W(ADDR_W), .N_ERR(NERR)) u_walk (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .start_addr(start_addr),
    .resume(resume), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .rx_trunc(rx_trunc), .rx_da_miss(rx_da_miss),
    .cmd_valid(cmd_valid), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .stat_word(stat_word), .stat_keep(stat_keep),
    .cap_errs(cap_errs), .cap_trunc(cap_trunc), .cap_damiss(cap_damiss),
    .ctl_flex(ctl_flex), .eof_accept(eof_accept), .rx_ready(rx_ready),
    .susp_req(susp_req), .eng_idle(eng_idle), .rbd_ptr(rbd_ptr),
    .rbd_attached(rbd_attached)
  );

  rfd_status_build #(.N_ERR(NERR)) u_build (
    .errs(cap_errs), .trunc(cap_trunc), .da_miss(cap_damiss), .flex(ctl_flex),
    .cfg_len_chk(cfg_len_chk), .cfg_save_bad(cfg_save_bad),
    .status(stat_word), .keep(stat_keep)
  );

  rfd_mem_port #(.ADDR_W(ADDR_W), .DATA_W(STAT_W)) u_port (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
    .rsp_done(rsp_done), .rsp_data(rsp_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  rfd_stat_strobe #(.N_ERR(NERR), .LEN_IDX(E_LEN)) u_stat (
    .clk(clk), .rst(rst), .accept(eof_accept), .errs(rx_err),
    .cfg_len_chk(cfg_len_chk), .pulse(stat_pulse)
  );

  assert_gap_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[4:2] == 3'b000));

  assert_ok_clean_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_wdata[ST_OK]) |-> (mem_wdata[12:5] == 8'h00 && !mem_wdata[0]));

  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_wdata[ST_DONE]) |-> !mem_wdata[ST_BUSY]);

  assert_trunc_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_wdata[ST_TRUNC]) |-> cfg_save_bad);

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_ready, susp_req, eng_idle}));
endmodule

// File: tb/tb_rfd_status_engine.sv
`timescale 1ns/1ps
module tb_rfd_status_engine;
  localparam int AW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, cfg_save_bad, cfg_len_chk, start_cmd, resume;
  logic          rx_sof, rx_eof, rx_trunc, rx_da_miss;
  logic [AW-1:0] start_addr;
  logic [7:0]    rx_err;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr, rbd_ptr;
  logic [15:0]   mem_wdata, mem_rdata;
  logic          rx_ready, susp_req, eng_idle, rbd_attached;
  logic [7:0]    stat_pulse;

  rfd_status_engine #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cfg_save_bad(cfg_save_bad), .cfg_len_chk(cfg_len_chk),
    .start_cmd(start_cmd), .start_addr(start_addr), .resume(resume),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .rx_trunc(rx_trunc),
    .rx_da_miss(rx_da_miss), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .rx_ready(rx_ready), .susp_req(susp_req),
    .eng_idle(eng_idle), .rbd_ptr(rbd_ptr), .rbd_attached(rbd_attached),
    .stat_pulse(stat_pulse)
  );

  // scoreboard queues: {we, addr, data}; reads carry data 0
  logic [32:0] acc_q[$];
  logic [7:0]  stat_q[$];
  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
  bit wd_fired = 0;

  // descriptor image
  function automatic logic [15:0] init_word(input int i);
    case (i)
      1: return 16'h0000;  2: return 16'h0008;  3: return 16'hFFFF;
      9: return 16'h0008; 10: return 16'h0010; 11: return 16'h0030;
      17: return 16'h4000; 18: return 16'h0018; 19: return 16'hFFFF;
      25: return 16'hC000; 26: return 16'h0000; 27: return 16'h0005;
      33: return 16'h0000; 34: return 16'h0000; 35: return 16'h0007;
      default: return 16'h0000;
    endcase
  endfunction

  // memory model and access monitor
  logic [15:0] mem [0:63];
  int wait_cnt, dly_seed;
  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] = init_word(i);
      mem_ack = 1'b0; mem_rdata = 16'h0; wait_cnt = 0; dly_seed = 1;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        logic [32:0] got;
        got = {mem_we, mem_addr, mem_we ? mem_wdata : 16'h0};
        if (mem_we) mem[mem_addr[5:0]] = mem_wdata;
        else        mem_rdata = mem[mem_addr[5:0]];
        mem_ack = 1'b1;
        mon_checks++;
        if (acc_q.size() == 0) begin
          mon_fails++;
          $display("FAIL R3 unexpected access actual=%h expected=none", got);
        end else begin
          logic [32:0] exp;
          exp = acc_q.pop_front();
          if (got !== exp) begin
            mon_fails++;
            $display("FAIL R2/R4/R5 access actual=%h expected=%h", got, exp);
          end
        end
        dly_seed = (dly_seed + 3) % 7;
        wait_cnt = dly_seed % 4;
      end
    end
  end

  // statistics monitor
  always @(negedge clk) begin
    if (!rst && stat_pulse != 8'h00) begin
      mon_checks++;
      if (stat_q.size() == 0) begin
        mon_fails++;
        $display("FAIL R13 stat_pulse actual=%h expected=00", stat_pulse);
      end else begin
        logic [7:0] e;
        e = stat_q.pop_front();
        if (stat_pulse !== e) begin
          mon_fails++;
          $display("FAIL R13 stat_pulse actual=%h expected=%h", stat_pulse, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [7:0] e, input logic tr, dm, sf,
                                           lc, sb, output logic keep);
    logic [15:0] w;
    logic bad;
    w = 16'h8000;
    if (e[0] && lc) w[12] = 1'b1;
    w[11] = e[1]; w[10] = e[2]; w[9] = e[3]; w[8] = e[4];
    w[7]  = e[5]; w[6]  = e[6]; w[0] = e[7];
    if (tr && !sf && sb) w[5] = 1'b1;
    w[1] = dm;
    bad  = (e[0] && lc) || (e[7:1] != 7'h0) || tr;
    if (!bad) w[13] = 1'b1;
    keep = !bad || sb;
    return w;
  endfunction

  task automatic push_fetch(input int a);
    acc_q.push_back({1'b0, 16'(a + 1), 16'h0});
    acc_q.push_back({1'b0, 16'(a + 2), 16'h0});
    acc_q.push_back({1'b0, 16'(a + 3), 16'h0});
  endtask

  task automatic drain();
    while (acc_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!rx_ready) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] e, input logic tr, dm, sf, input int da,
                            input int next_fetch);
    logic keep;
    logic [15:0] w;
    logic [7:0] se;
    w = exp_word(e, tr, dm, sf, cfg_len_chk, cfg_save_bad, keep);
    se = e; se[0] = e[0] & cfg_len_chk;
    wait_ready();
    acc_q.push_back({1'b1, 16'(da), 16'h4000});
    acc_q.push_back({1'b1, 16'(da), keep ? w : 16'h0000});
    if (next_fetch >= 0) push_fetch(next_fetch);
    if (se != 8'h0) stat_q.push_back(se);
    @(negedge clk) rx_sof = 1'b1;
    @(negedge clk) rx_sof = 1'b0;
    repeat (2) @(negedge clk);
    rx_err = e; rx_trunc = tr; rx_da_miss = dm; rx_eof = 1'b1;
    @(negedge clk);
    rx_eof = 1'b0; rx_err = 8'h0; rx_trunc = 1'b0; rx_da_miss = 1'b0;
  endtask

  task automatic run_all();
    // R1 reset state
    rst = 1'b1; cfg_save_bad = 0; cfg_len_chk = 0; start_cmd = 0; resume = 0;
    rx_sof = 0; rx_eof = 0; rx_err = 0; rx_trunc = 0; rx_da_miss = 0; start_addr = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(eng_idle && !mem_req && !susp_req && !rx_ready && stat_pulse == 0, "R1 reset",
        {eng_idle, mem_req, susp_req, rx_ready}, 4'b1000);

    // R2 start fetch, R12 no buffer
    push_fetch(0);
    start_addr = 16'h0000; start_cmd = 1'b1;
    @(negedge clk) start_cmd = 1'b0;
    wait_ready(); drain();
    chk(rx_ready == 1'b1, "R2 ready after fetch", rx_ready, 1);
    chk(rbd_attached == 1'b0, "R12 all-ones pointer", rbd_attached, 0);

    // R5 good frame, R9 follow link to 8
    send_frame(8'h00, 0, 1, 0, 0, 8); drain();
    chk(rbd_attached == 1'b1 && rbd_ptr == 16'h0030, "R12 pointer", rbd_ptr, 16'h0030);

    // R8 discard, same descriptor re-armed, R13 stats
    send_frame(8'h02, 0, 0, 1, 8, -1); drain();
    chk(rx_ready == 1'b1, "R8 re-armed", rx_ready, 1);

    // R6 length masked, R7 trunc hidden in flexible mode
    cfg_save_bad = 1;
    send_frame(8'h05, 1, 0, 1, 8, 16'h10); drain();

    // R6 length counted, R7 trunc shown, R11 suspend
    cfg_len_chk = 1;
    send_frame(8'hA1, 1, 0, 0, 16'h10, -1); drain();
    chk(susp_req == 1'b1, "R11 suspended", susp_req, 1);
    // R4 frame events ignored while suspended
    rx_sof = 1'b1; @(negedge clk) rx_sof = 1'b0;
    rx_err = 8'hFF; rx_eof = 1'b1; @(negedge clk) rx_eof = 1'b0; rx_err = 8'h0;
    repeat (6) @(negedge clk);
    chk(susp_req == 1'b1 && !mem_req, "R4 events ignored", susp_req, 1);

    // R11 resume follows link 0x18
    push_fetch(16'h18);
    resume = 1'b1; @(negedge clk) resume = 1'b0;
    wait_ready(); drain();
    chk(rbd_ptr == 16'h0005, "R11 resumed to link", rbd_ptr, 5);

    // R10 end of list, start_cmd held through the final write acknowledge
    cfg_save_bad = 0; cfg_len_chk = 0;
    send_frame(8'h00, 0, 0, 0, 16'h18, -1);
    start_addr = 16'h0020; start_cmd = 1'b1;
    do @(posedge clk); while (!(mem_ack && mem_we && mem_addr == 16'h0018 && mem_wdata[15]));
    @(negedge clk) start_cmd = 1'b0;
    repeat (8) @(negedge clk);
    chk(eng_idle == 1'b1 && susp_req == 1'b0, "R10 idle after end of list",
        {eng_idle, susp_req}, 2'b10);
    chk(acc_q.size() == 0, "R10 no fetch", acc_q.size(), 0);

    // R9 cyclic list: 0x20 links back to head 0
    push_fetch(16'h20);
    start_cmd = 1'b1; @(negedge clk) start_cmd = 1'b0;
    wait_ready(); drain();
    chk(rbd_ptr == 16'h0007, "R9 start at 0x20", rbd_ptr, 7);
    send_frame(8'h00, 0, 0, 0, 16'h20, 0); drain();
    chk(rbd_attached == 1'b0, "R9 wrapped to head", rbd_attached, 0);
    send_frame(8'h80, 0, 1, 0, 0, -1); drain();   // R8 collision discarded
    chk(rx_ready == 1'b1, "R8 collision discard", rx_ready, 1);

    // R10 start ignored when not idle
    start_addr = 16'h0010; start_cmd = 1'b1; @(negedge clk) start_cmd = 1'b0;
    repeat (8) @(negedge clk);
    chk(rx_ready == 1'b1 && !mem_req, "R10 start ignored", rx_ready, 1);
    chk(stat_q.size() == 0, "R13 all strobes seen", stat_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (100000) @(posedge clk); wd_fired = 1; end
    join_any
    disable fork;
    if (wd_fired) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    checks++;
    if (acc_q.size() != 0) begin
      fails++;
      $display("FAIL R3 pending accesses actual=%0d expected=0", acc_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  end
endmodule